// File: doc/BRIEF.md
# Terminal Multiplexer Line Register Bank

This block is the bus-facing register file of a terminal multiplexer with up to sixteen serial lines. Every line owns four 16-bit word registers: a receive control/status word, a receive data byte, a transmit control/status word and a transmit data byte. A bus master reaches them through a single address window. The block decodes the line and the register from the address, merges byte writes, and applies separate read and write masks to both status words.

On the line side, a receiver hands in characters through a one-cycle strobe. The block stores each character, flags overrun when the previous one was never taken, and can overwrite bit 7 with a computed odd or even parity bit. It also reports whether the stored byte has odd parity. A transmitter is started by a one-cycle start strobe carrying line and byte, and answers with a done strobe. A line-status source updates the carrier, ring, carrier-change and clear-to-send bits through an update strobe. Per-line receive and transmit request vectors go to an external arbiter.

Top module: `tmux_csr_bank`

## Requirements
- R1: The line index is `(bus_addr - BASE_ADDR) >> 3`, taken modulo NUM_LINES. `bus_addr[2:1]` picks the register: 0 receive status, 1 receive data, 2 transmit status, 3 transmit data.
- R2: After reset both data registers of every line read 0, every receive status word reads 0, every transmit status word reads 0x0080, and all request outputs are low.
- R3: In the receive status word, bits 0, 1, 3, 4, 6, 8, 9 and 10 are writable. Bit 11 always reads 0. Bit 15 reads as the OR of overrun (bit 12), ring (bit 13) and carrier change (bit 14).
- R4: In the transmit status word, bits 0, 2, 3, 4, 6 and 8 are writable, and bits 9 to 15 read 0.
- R5: When `bus_byte` is set, the byte travels in `bus_wdata[7:0]`. An odd address replaces bits 15:8 and keeps bits 7:0. An even address replaces bits 7:0 and keeps bits 15:8.
- R6: A read of the receive status word returns the value defined in R3, then clears done (bit 7) and bits 12, 13 and 14.
- R7: A received character is stored in the receive data register. If done is clear, done is set; if done is already set, overrun is set. When interrupt enable (bit 6) is set, the line's receive request is raised.
- R8: `par_mode` 1 replaces bit 7 with odd parity over bits 6:0, and 2 replaces it with even parity. Modes 0 and 3 keep the character as received. Status bit 5 is set when bit 7 of the stored byte makes the byte odd-parity overall.
- R9: A read of the receive data register drops the line's receive request. Writes to that register change nothing.
- R10: Writing either status word with bit 6 as 0 drops that word's request. Writing it with bit 6 as 1 raises the request only if done was set and bit 6 was clear before the write.
- R11: Any write to the transmit data register clears transmit done and the transmit request. It also pulses `tx_start_vld` in the following cycle, carrying the line and the buffer byte. Only an even-address write loads `bus_wdata[7:0]` into the buffer.
- R12: A `tx_done_vld` strobe sets transmit done and raises the transmit request if bit 6 is set.
- R13: A `st_upd` strobe copies `st_cd` into receive bit 2 and `st_cts` into transmit bit 1. It also sets receive bit 13 when `st_ring` is high and bit 14 when `st_cch` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | Byte write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| par_mode | input | 2 | Receive parity mode |
| rx_valid | input | 1 | Received character strobe |
| rx_line | input | LINE_W | Line of received character |
| rx_char | input | 8 | Received character |
| st_upd | input | 1 | Line status update strobe |
| st_line | input | LINE_W | Line of status update |
| st_cd | input | 1 | Carrier detect level |
| st_ring | input | 1 | Ring event |
| st_cch | input | 1 | Carrier change event |
| st_cts | input | 1 | Clear-to-send level |
| tx_done_vld | input | 1 | Transmit completion strobe |
| tx_done_line | input | LINE_W | Line that completed |
| tx_start_vld | output | 1 | Transmit start strobe |
| tx_start_line | output | LINE_W | Line to transmit on |
| tx_start_data | output | 8 | Byte to transmit |
| rx_irq | output | NUM_LINES | Receive request per line |
| tx_irq | output | NUM_LINES | Transmit request per line |

## Verification
On every cycle, the assertions check four things. A request is only ever held while its enable bit is set. A transmit buffer write clears done and is followed by a start strobe. A status read with no competing event leaves done and the three error bits clear. A character arriving on top of an unread one sets overrun. Only the bench's scenarios can show the read values and masks as seen through the address decode, including the alias above the last line. The same holds for byte-lane merging, the parity insertion results over all 256 characters in each mode, and the exact ordering of request raise and withdraw across write sequences.

// File: rtl/tmux_pkg.sv
package tmux_pkg;

    localparam logic [15:0] RXS_RD_MASK = 16'o173777;
    localparam logic [15:0] RXS_WR_MASK = 16'o003533;
    localparam logic [15:0] TXS_RD_MASK = 16'o100737;
    localparam logic [15:0] TXS_WR_MASK = 16'o000535;

    localparam int unsigned B_CD   = 2;
    localparam int unsigned B_CTS  = 1;
    localparam int unsigned B_PAR  = 5;
    localparam int unsigned B_IE   = 6;
    localparam int unsigned B_DONE = 7;
    localparam int unsigned B_OVR  = 12;
    localparam int unsigned B_RING = 13;
    localparam int unsigned B_CCH  = 14;
    localparam int unsigned B_SUM  = 15;

    typedef enum logic [1:0] {
        SEL_RXS = 2'd0,
        SEL_RXB = 2'd1,
        SEL_TXS = 2'd2,
        SEL_TXB = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PAR_KEEP  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_EVEN  = 2'd2,
        PAR_KEEP2 = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [15:0] rx_csr;
        logic [7:0]  rx_buf;
        logic [15:0] tx_csr;
        logic [7:0]  tx_buf;
        logic        rx_irq;
        logic        tx_irq;
    } line_state_t;

    // bit that makes a 7-bit value odd-weight when placed on top
    function automatic logic odd_fill(input logic [6:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/tmux_addr_dec.sv
module tmux_addr_dec
    import tmux_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 16,
    parameter int unsigned          LINE_W    = 4,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LINE_W-1:0] line,
    output reg_sel_e          sel,
    output logic              hi_byte
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset  = addr - BASE_ADDR;
        line    = offset[LINE_W+2:3];
        sel     = reg_sel_e'(addr[2:1]);
        hi_byte = addr[0];
    end

    logic unused_offset;
    assign unused_offset = ^{offset[ADDR_W-1:LINE_W+3], offset[2:0]};
endmodule

// File: rtl/tmux_rx_shape.sv
module tmux_rx_shape
    import tmux_pkg::*;
(
    input  par_mode_e  mode,
    input  logic [7:0] char_in,
    output logic [7:0] char_out,
    output logic       odd_flag
);
    logic fill;

    always_comb begin
        fill = odd_fill(char_in[6:0]);
        unique case (mode)
            PAR_ODD:  char_out = {fill, char_in[6:0]};
            PAR_EVEN: char_out = {~fill, char_in[6:0]};
            default:  char_out = char_in;
        endcase
        odd_flag = (char_out[7] == odd_fill(char_out[6:0]));
    end
endmodule

// File: rtl/tmux_line_regs.sv
module tmux_line_regs
    import tmux_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_wr,
    input  logic        acc_rd,
    input  reg_sel_e    sel,
    input  logic        byte_wr,
    input  logic        hi_byte,
    input  logic [15:0] wdata,
    input  logic        rx_put,
    input  logic [7:0]  rx_data,
    input  logic        rx_odd,
    input  logic        st_upd,
    input  logic        st_cd,
    input  logic        st_ring,
    input  logic        st_cch,
    input  logic        st_cts,
    input  logic        tx_fin,
    output logic [15:0] rd_val,
    output logic        rx_irq,
    output logic        tx_irq,
    output logic [7:0]  tx_buf
);
    line_state_t q, d;
    logic [15:0] cur_word;
    logic [15:0] merged;
    logic        err_any;

    always_comb begin
        cur_word = (sel == SEL_TXS) ? q.tx_csr : q.rx_csr;
        if (!byte_wr)
            merged = wdata;
        else if (hi_byte)
            merged = {wdata[7:0], cur_word[7:0]};
        else
            merged = {cur_word[15:8], wdata[7:0]};
        err_any = q.rx_csr[B_OVR] | q.rx_csr[B_RING] | q.rx_csr[B_CCH];

        d = q;
        // bus side
        if (acc_wr) begin
            unique case (sel)
                SEL_RXS: begin
                    if (!merged[B_IE])
                        d.rx_irq = 1'b0;
                    else if (q.rx_csr[B_DONE] && !q.rx_csr[B_IE])
                        d.rx_irq = 1'b1;
                    d.rx_csr = (q.rx_csr & ~RXS_WR_MASK) | (merged & RXS_WR_MASK);
                end
                SEL_TXS: begin
                    if (!merged[B_IE])
                        d.tx_irq = 1'b0;
                    else if (q.tx_csr[B_DONE] && !q.tx_csr[B_IE])
                        d.tx_irq = 1'b1;
                    d.tx_csr = (q.tx_csr & ~TXS_WR_MASK) | (merged & TXS_WR_MASK);
                end
                SEL_TXB: begin
                    if (!hi_byte)
                        d.tx_buf = wdata[7:0];
                    d.tx_csr[B_DONE] = 1'b0;
                    d.tx_irq         = 1'b0;
                end
                default: ;
            endcase
        end else if (acc_rd) begin
            if (sel == SEL_RXS) begin
                d.rx_csr[B_DONE] = 1'b0;
                d.rx_csr[B_OVR]  = 1'b0;
                d.rx_csr[B_RING] = 1'b0;
                d.rx_csr[B_CCH]  = 1'b0;
            end else if (sel == SEL_RXB) begin
                d.rx_irq = 1'b0;
            end
        end
        // line status source
        if (st_upd) begin
            d.rx_csr[B_CD] = st_cd;
            d.tx_csr[B_CTS] = st_cts;
            if (st_ring) d.rx_csr[B_RING] = 1'b1;
            if (st_cch)  d.rx_csr[B_CCH]  = 1'b1;
        end
        // receiver, applied after any clear-on-read of this cycle
        if (rx_put) begin
            if (d.rx_csr[B_DONE])
                d.rx_csr[B_OVR] = 1'b1;
            else
                d.rx_csr[B_DONE] = 1'b1;
            d.rx_buf        = rx_data;
            d.rx_csr[B_PAR] = rx_odd;
            if (d.rx_csr[B_IE])
                d.rx_irq = 1'b1;
        end
        // transmitter completion
        if (tx_fin) begin
            d.tx_csr[B_DONE] = 1'b1;
            if (d.tx_csr[B_IE])
                d.tx_irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            q.tx_csr[B_DONE] <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RXS: rd_val = (q.rx_csr | {err_any, 15'b0}) & RXS_RD_MASK;
            SEL_RXB: rd_val = {8'h00, q.rx_buf};
            SEL_TXS: rd_val = q.tx_csr & TXS_RD_MASK;
            default: rd_val = {8'h00, q.tx_buf};
        endcase
    end

    assign rx_irq = q.rx_irq;
    assign tx_irq = q.tx_irq;
    assign tx_buf = q.tx_buf;

    assert_rx_irq_needs_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_irq |-> q.rx_csr[B_IE]);
    assert_tx_irq_needs_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.tx_irq |-> q.tx_csr[B_IE]);
    assert_txb_write_clears_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && sel == SEL_TXB && !tx_fin) |=> !q.tx_csr[B_DONE] && !q.tx_irq);
    assert_overrun_on_unread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_put && q.rx_csr[B_DONE] && !(acc_rd && sel == SEL_RXS)) |=> q.rx_csr[B_OVR]);
    assert_read_clears_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && sel == SEL_RXS && !rx_put && !st_upd)
        |=> (q.rx_csr[14:12] == 3'b000 && !q.rx_csr[B_DONE]));
    assert_rxb_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && sel == SEL_RXB && !rx_put) |=> $stable(q.rx_buf));
endmodule

// File: rtl/tmux_csr_bank.sv
module tmux_csr_bank
    import tmux_pkg::*;
#(
    parameter int unsigned       NUM_LINES = 16,
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hE000,
    localparam int unsigned      LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic                 bus_byte,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    input  logic [1:0]           par_mode,
    input  logic                 rx_valid,
    input  logic [LINE_W-1:0]    rx_line,
    input  logic [7:0]           rx_char,
    input  logic                 st_upd,
    input  logic [LINE_W-1:0]    st_line,
    input  logic                 st_cd,
    input  logic                 st_ring,
    input  logic                 st_cch,
    input  logic                 st_cts,
    input  logic                 tx_done_vld,
    input  logic [LINE_W-1:0]    tx_done_line,
    output logic                 tx_start_vld,
    output logic [LINE_W-1:0]    tx_start_line,
    output logic [7:0]           tx_start_data,
    output logic [NUM_LINES-1:0] rx_irq,
    output logic [NUM_LINES-1:0] tx_irq
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic [7:0]        data;
    } start_t;

    logic [LINE_W-1:0] dec_line;
    reg_sel_e          dec_sel;
    logic              dec_hi;
    logic [7:0]        rx_shaped;
    logic              rx_odd;
    logic [15:0]       rd_val  [NUM_LINES];
    logic [7:0]        txb_all [NUM_LINES];
    start_t            start_d, start_q;

    tmux_addr_dec #(
        .ADDR_W    (ADDR_W),
        .LINE_W    (LINE_W),
        .BASE_ADDR (BASE_ADDR)
    ) addr_dec_i (
        .addr    (bus_addr),
        .line    (dec_line),
        .sel     (dec_sel),
        .hi_byte (dec_hi)
    );

    tmux_rx_shape rx_shape_i (
        .mode     (par_mode_e'(par_mode)),
        .char_in  (rx_char),
        .char_out (rx_shaped),
        .odd_flag (rx_odd)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit;
        assign hit = (dec_line == LINE_W'(g));
        tmux_line_regs line_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_wr  (bus_sel && bus_wr && hit),
            .acc_rd  (bus_sel && !bus_wr && hit),
            .sel     (dec_sel),
            .byte_wr (bus_byte),
            .hi_byte (dec_hi),
            .wdata   (bus_wdata),
            .rx_put  (rx_valid && rx_line == LINE_W'(g)),
            .rx_data (rx_shaped),
            .rx_odd  (rx_odd),
            .st_upd  (st_upd && st_line == LINE_W'(g)),
            .st_cd   (st_cd),
            .st_ring (st_ring),
            .st_cch  (st_cch),
            .st_cts  (st_cts),
            .tx_fin  (tx_done_vld && tx_done_line == LINE_W'(g)),
            .rd_val  (rd_val[g]),
            .rx_irq  (rx_irq[g]),
            .tx_irq  (tx_irq[g]),
            .tx_buf  (txb_all[g])
        );
    end

    always_comb begin
        bus_rdata = (bus_sel && !bus_wr) ? rd_val[dec_line] : 16'h0000;

        start_d      = '0;
        start_d.vld  = bus_sel && bus_wr && (dec_sel == SEL_TXB);
        start_d.line = dec_line;
        start_d.data = dec_hi ? txb_all[dec_line] : bus_wdata[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else
            start_q <= start_d;
    end

    assign tx_start_vld  = start_q.vld;
    assign tx_start_line = start_q.line;
    assign tx_start_data = start_q.data;

    assert_start_follows_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && dec_sel == SEL_TXB) |=> tx_start_vld);
    assert_start_only_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_vld |-> $past(bus_sel && bus_wr));
endmodule

// File: tb/tmux_csr_bank_tb.sv
module tmux_csr_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int LW = 4;
    localparam logic [15:0] BASE = 16'hE000;
    localparam logic [15:0] RX_WM = 16'o003533;
    localparam logic [15:0] TX_WM = 16'o000535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_byte = 0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  par_mode = 0;
    logic rx_valid = 0;
    logic [LW-1:0] rx_line = '0;
    logic [7:0] rx_char = '0;
    logic st_upd = 0, st_cd = 0, st_ring = 0, st_cch = 0, st_cts = 0;
    logic [LW-1:0] st_line = '0;
    logic tx_done_vld = 0;
    logic [LW-1:0] tx_done_line = '0;
    logic tx_start_vld;
    logic [LW-1:0] tx_start_line;
    logic [7:0] tx_start_data;
    logic [NL-1:0] rx_irq, tx_irq;

    int checks = 0;
    int fails = 0;
    int st_cnt = 0;
    logic [LW-1:0] st_seen_line = '0;
    logic [7:0] st_seen_data = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmux_csr_bank #(.NUM_LINES(NL), .ADDR_W(16), .BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .par_mode(par_mode),
        .rx_valid(rx_valid), .rx_line(rx_line), .rx_char(rx_char), .st_upd(st_upd),
        .st_line(st_line), .st_cd(st_cd), .st_ring(st_ring), .st_cch(st_cch), .st_cts(st_cts),
        .tx_done_vld(tx_done_vld), .tx_done_line(tx_done_line), .tx_start_vld(tx_start_vld),
        .tx_start_line(tx_start_line), .tx_start_data(tx_start_data), .rx_irq(rx_irq),
        .tx_irq(tx_irq)
    );

    always @(negedge clk) begin
        if (rst_n && tx_start_vld) begin
            st_cnt++;
            st_seen_line = tx_start_line;
            st_seen_data = tx_start_data;
        end
    end

    function automatic logic [15:0] ra(input int ln, input int sel);
        return BASE + 16'(ln * 8) + 16'(sel * 2);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bwrite(input logic [15:0] a, input logic [15:0] dat, input bit byt);
        bus_sel = 1; bus_wr = 1; bus_byte = byt; bus_addr = a; bus_wdata = dat;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_byte = 0;
    endtask

    task automatic bread(input logic [15:0] a, output logic [15:0] dat);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 dat = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rxput(input int ln, input logic [7:0] c);
        rx_valid = 1; rx_line = LW'(ln); rx_char = c;
        @(posedge clk); @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic stat(input int ln, input bit cd, input bit rg, input bit cc, input bit ct);
        st_upd = 1; st_line = LW'(ln); st_cd = cd; st_ring = rg; st_cch = cc; st_cts = ct;
        @(posedge clk); @(negedge clk);
        st_upd = 0;
    endtask

    // expected stored byte and odd-weight flag for a received character
    function automatic logic [8:0] shape(input int mode, input logic [7:0] c);
        logic [7:0] b;
        logic ones_odd7;
        ones_odd7 = ^c[6:0];
        if (mode == 1)      b = {~ones_odd7, c[6:0]};
        else if (mode == 2) b = {ones_odd7, c[6:0]};
        else                b = c;
        return {(^b) == 1'b1, b};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] p;
        logic [8:0] e;
        int cnt0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 reset state, R1 every line decodes
        check("R2", "rx_irq after reset", 32'(rx_irq), 0);
        check("R2", "tx_irq after reset", 32'(tx_irq), 0);
        for (int ln = 0; ln < NL; ln++) begin
            bread(ra(ln, 0), v); check("R2", "rx status reset", 32'(v), 32'h0000);
            bread(ra(ln, 1), v); check("R2", "rx data reset", 32'(v), 32'h0000);
            bread(ra(ln, 2), v); check("R2", "tx status reset", 32'(v), 32'h0080);
            bread(ra(ln, 3), v); check("R2", "tx data reset", 32'(v), 32'h0000);
        end

        // R1 R3 R4 per-line distinct patterns through the write masks
        for (int ln = 0; ln < NL; ln++) begin
            p = 16'hA5C3 ^ 16'(ln * 16'h1111);
            bwrite(ra(ln, 0), p, 0);
            bwrite(ra(ln, 2), ~p, 0);
        end
        for (int ln = 0; ln < NL; ln++) begin
            p = 16'hA5C3 ^ 16'(ln * 16'h1111);
            bread(ra(ln, 0), v); check("R3", "rx status masked write", 32'(v), 32'(p & RX_WM));
            bread(ra(ln, 2), v); check("R4", "tx status masked write", 32'(v), 32'((~p & TX_WM) | 16'h0080));
        end
        for (int ln = 0; ln < NL; ln++) begin
            bwrite(ra(ln, 0), 16'h0000, 0);
            bwrite(ra(ln, 2), 16'h0000, 0);
        end
        check("R10", "tx_irq cleared by IE=0 writes", 32'(tx_irq), 0);
        bwrite(ra(3, 0), 16'hFFFF, 0);
        bread(ra(3, 0), v); check("R3", "bit 11 and bit 15 read 0", 32'(v), 32'(RX_WM));
        bwrite(ra(3, 2), 16'hFFFF, 0);
        bread(ra(3, 2), v); check("R4", "tx bits 9-15 read 0", 32'(v), 32'(TX_WM | 16'h0080));
        bwrite(ra(3, 2), 16'h0000, 0);

        // R1 alias above the last line lands on line 0
        bwrite(BASE + 16'(NL * 8), 16'h0001, 0);
        bread(ra(0, 0), v); check("R1", "alias write to line 0", 32'(v), 32'h0001);
        bwrite(ra(0, 0), 16'h0000, 0);

        // R5 byte lanes
        bwrite(ra(3, 0), 16'h0000, 0);
        bwrite(ra(3, 0) + 16'd1, 16'h0007, 1);
        bread(ra(3, 0), v); check("R5", "high byte write", 32'(v), 32'h0700 & 32'(RX_WM));
        bwrite(ra(3, 0), 16'hAAFF, 1);
        bread(ra(3, 0), v); check("R5", "low byte write keeps high", 32'(v), 32'h07FF & 32'(RX_WM));
        bwrite(ra(3, 0) + 16'd1, 16'h0000, 1);
        bread(ra(3, 0), v); check("R5", "high byte write keeps low", 32'(v), 32'h00FF & 32'(RX_WM));
        bwrite(ra(3, 0), 16'h0000, 0);

        // R7 R6 reception, overrun, clear on read
        rxput(2, 8'h41);
        bread(ra(2, 0), v); check("R7", "done after char", 32'(v), 32'h0080);
        bread(ra(2, 0), v); check("R6", "done cleared by read", 32'(v), 32'h0000);
        bread(ra(2, 1), v); check("R7", "char stored", 32'(v), 32'h0041);
        rxput(2, 8'h10);
        rxput(2, 8'h20);
        bread(ra(2, 0), v); check("R6", "overrun with summary", 32'(v), 32'h90A0);
        bread(ra(2, 0), v); check("R6", "overrun cleared by read", 32'(v), 32'h0020);
        bread(ra(2, 1), v); check("R7", "latest char kept", 32'(v), 32'h0020);

        // R9 rx data writes ignored
        bwrite(ra(2, 1), 16'hFFFF, 0);
        bread(ra(2, 1), v); check("R9", "rx data write ignored", 32'(v), 32'h0020);

        // R8 parity sweep on line 5
        for (int m = 0; m < 4; m++) begin
            par_mode = 2'(m);
            for (int c = 0; c < 256; c++) begin
                e = shape(m, 8'(c));
                rxput(5, 8'(c));
                bread(ra(5, 1), v); check("R8", "stored byte", 32'(v), 32'(e[7:0]));
                bread(ra(5, 0), v); check("R8", "parity status", 32'(v), 32'h0080 | (e[8] ? 32'h20 : 32'h0));
            end
        end
        par_mode = 0;

        // R7 R9 R10 receive requests on line 1
        bwrite(ra(1, 0), 16'h0040, 0);
        check("R10", "no request with done clear", 32'(rx_irq), 0);
        rxput(1, 8'h41);
        check("R7", "request on char", 32'(rx_irq), 32'h0002);
        bread(ra(1, 1), v);
        check("R9", "data read drops request", 32'(rx_irq), 0);
        rxput(1, 8'h41);
        check("R7", "request on overrun char", 32'(rx_irq), 32'h0002);
        bwrite(ra(1, 0), 16'h0000, 0);
        check("R10", "IE=0 drops request", 32'(rx_irq), 0);
        bwrite(ra(1, 0), 16'h0040, 0);
        check("R10", "IE rise with done raises", 32'(rx_irq), 32'h0002);
        bread(ra(1, 1), v);
        bwrite(ra(1, 0), 16'h0040, 0);
        check("R10", "IE already set no raise", 32'(rx_irq), 0);
        bread(ra(1, 0), v); check("R6", "status before clear", 32'(v), 32'h90C0);
        bwrite(ra(1, 0), 16'h0000, 0);

        // R10 R11 R12 transmit on line 6
        bwrite(ra(6, 2), 16'h0040, 0);
        check("R10", "tx IE rise with done raises", 32'(tx_irq), 32'h0040);
        cnt0 = st_cnt;
        bwrite(ra(6, 3), 16'h1234, 0);
        check("R11", "tx write drops request", 32'(tx_irq), 0);
        @(negedge clk);
        check("R11", "start pulse count", 32'(st_cnt - cnt0), 1);
        check("R11", "start line", 32'(st_seen_line), 6);
        check("R11", "start data", 32'(st_seen_data), 32'h34);
        bread(ra(6, 2), v); check("R11", "tx done cleared", 32'(v), 32'h0040);
        bread(ra(6, 3), v); check("R11", "tx low byte loaded", 32'(v), 32'h0034);
        bwrite(ra(6, 3) + 16'd1, 16'h0099, 1);
        @(negedge clk);
        check("R11", "odd write starts", 32'(st_cnt - cnt0), 2);
        check("R11", "odd write sends old byte", 32'(st_seen_data), 32'h34);
        bread(ra(6, 3), v); check("R11", "odd write keeps buffer", 32'(v), 32'h0034);
        tx_done_vld = 1; tx_done_line = 4'd6;
        @(posedge clk); @(negedge clk);
        tx_done_vld = 0;
        check("R12", "done raises request", 32'(tx_irq), 32'h0040);
        bread(ra(6, 2), v); check("R12", "done set", 32'(v), 32'h00C0);
        bwrite(ra(6, 3), 16'h0077, 1);
        bread(ra(6, 3), v); check("R11", "even byte write loads", 32'(v), 32'h0077);
        check("R11", "no stray starts", 32'(st_cnt - cnt0), 3);

        // R13 status updates on line 7
        stat(7, 1, 1, 1, 1);
        bread(ra(7, 0), v); check("R13", "status bits set", 32'(v), 32'hE004);
        bread(ra(7, 2), v); check("R13", "cts set", 32'(v), 32'h0082);
        bread(ra(7, 0), v); check("R6", "ring/change cleared, cd kept", 32'(v), 32'h0004);
        stat(7, 0, 0, 0, 0);
        bread(ra(7, 0), v); check("R13", "cd cleared", 32'(v), 32'h0000);
        bread(ra(7, 2), v); check("R13", "cts cleared", 32'(v), 32'h0080);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule